// File: doc/BRIEF.md
# Cached DRAM Access Sequencer

This block sequences single-nibble reads and writes to a memory built from a large DRAM array with a small direct-mapped SRAM line cache in front of it. A requester presents a full address, not split into row and column, together with a write flag and a bypass flag. It hands the request over with a valid/ready handshake. Each accepted request returns exactly one response pulse with a 4-bit data value. A write returns the data it wrote.

Cache hits finish in one cycle, and a new request can be accepted on every cycle. A miss moves a whole 16-nibble line between the array and the cache in a single wide transfer. A dirty victim line is first copied back to the array. The requester is released after the miss access time, and the array then stays occupied in the background while further hits are served. A bypass access goes straight to the array with its own latency and occupancy. A power-down input freezes the whole block in place.

Top module: `cdram_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0, every line is invalid and clean, and the array is free, so the first cached read of any address is a miss.
- R2: A cached read hit accepted in cycle N gives `rsp_valid_o` with the cached nibble in cycle N+1, and a following request can be accepted in cycle N+1.
- R3: A cached access that misses and is accepted in cycle N gives its response in cycle N+7. `req_ready_o` is 0 in cycles N+1 to N+6. The address splits into offset = addr[3:0], set = addr[11:4] and tag = the bits above 11.
- R4: After a miss accepted in cycle N, hits can be accepted from cycle N+7 onward. A request that needs the array (a miss or a bypass access) is held with `req_ready_o` = 0 until cycle N+28.
- R5: A bypass access (`req_direct_i` = 1) accepted in cycle N responds in cycle N+7 and occupies the array until cycle N+14. It never allocates a line, so a later cached read of the same address misses.
- R6: A cached write hit responds with the written nibble one cycle after acceptance and marks the line dirty. Later reads of that address return the new value.
- R7: A miss on a set holding a dirty line copies that line back to the array before the new line is filled, so written data survives eviction.
- R8: A bypass write to an address whose line is cached updates the array and invalidates the line. If the line was dirty, the line with the new nibble merged in is written to the array first. The next cached read of that line misses and returns current data.
- R9: While `pd_i` is 1, `req_ready_o` and `rsp_valid_o` are 0 and no state changes. A pending response and all cached contents are delivered unchanged after `pd_i` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down: freezes all state |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_direct_i | input | 1 | 1 = bypass the cache and access the array |
| req_addr_i | input | ADDR_W | Full nibble address {tag, set, offset} |
| req_wdata_i | input | 4 | Write nibble |
| rsp_valid_o | output | 1 | Response pulse, one per accepted request |
| rsp_rdata_o | output | 4 | Read nibble, or the written nibble for writes |

## Verification
A wrong tag, valid or dirty bit shows at the ports on the very next access to that set. The response latency changes between 1 and 7 cycles, or a later read after eviction or bypass invalidation returns stale data. A wrong array-occupancy count shows as a shifted acceptance cycle for the next miss or bypass request. Hits keep their one-cycle timing in that case, so the bench measures the spacing of acceptance cycles as well as the response latency and data.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
  localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/cdram_array.sv
module cdram_array #(
  parameter  int unsigned IDX_W  = 10,
  parameter  int unsigned OFS_W  = 4,
  localparam int unsigned LINES  = 1 << IDX_W,
  localparam int unsigned LINE_W = cdram_pkg::NIB_W << OFS_W
) (
  input  logic                   clk_i,
  input  logic                   en_i,
  input  logic                   line_we_i,
  input  logic [IDX_W-1:0]       line_wr_idx_i,
  input  logic [LINE_W-1:0]      line_wr_data_i,
  input  logic                   nib_we_i,
  input  logic [IDX_W+OFS_W-1:0] nib_addr_i,
  input  logic [3:0]             nib_data_i,
  input  logic [IDX_W-1:0]       line_rd_idx_i,
  output logic [LINE_W-1:0]      line_rd_o
);
  logic [LINE_W-1:0] mem_q [LINES];
  logic [OFS_W+1:0]  bpos;

  assign bpos      = {nib_addr_i[OFS_W-1:0], 2'b00};
  assign line_rd_o = mem_q[line_rd_idx_i];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (line_we_i) mem_q[line_wr_idx_i] <= line_wr_data_i;
      else if (nib_we_i) mem_q[nib_addr_i[IDX_W+OFS_W-1:OFS_W]][bpos +: 4] <= nib_data_i;
    end
  end
endmodule

// File: rtl/cdram_cache.sv
module cdram_cache #(
  parameter  int unsigned SET_W  = 8,
  parameter  int unsigned TAG_W  = 2,
  parameter  int unsigned OFS_W  = 4,
  localparam int unsigned SETS   = 1 << SET_W,
  localparam int unsigned LINE_W = cdram_pkg::NIB_W << OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic              vic_dirty_o,
  output logic [TAG_W-1:0]  vic_tag_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              fill_dirty_i,
  input  logic              nib_we_i,
  input  logic [OFS_W-1:0]  nib_ofs_i,
  input  logic [3:0]        nib_data_i,
  input  logic              inv_i
);
  logic [SETS-1:0]   vld_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];
  logic [OFS_W+1:0]  bpos;

  assign bpos        = {nib_ofs_i, 2'b00};
  assign hit_o       = vld_q[set_i] && (tag_q[set_i] == tag_i);
  assign vic_dirty_o = vld_q[set_i] && dirty_q[set_i];
  assign vic_tag_o   = tag_q[set_i];
  assign line_o      = data_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (en_i) begin
      if (fill_i) begin
        vld_q[set_i]   <= 1'b1;
        dirty_q[set_i] <= fill_dirty_i;
      end else if (nib_we_i) begin
        dirty_q[set_i] <= 1'b1;
      end else if (inv_i) begin
        vld_q[set_i]   <= 1'b0;
        dirty_q[set_i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (fill_i) begin
        tag_q[set_i]  <= tag_i;
        data_q[set_i] <= fill_line_i;
      end else if (nib_we_i) begin
        data_q[set_i][bpos +: 4] <= nib_data_i;
      end
    end
  end

  p_fill_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && fill_i |=> vld_q[$past(set_i)] && (tag_q[$past(set_i)] == $past(tag_i)));
  p_wr_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && nib_we_i |=> dirty_q[$past(set_i)]);
  p_inv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && inv_i |=> !vld_q[$past(set_i)]);
  p_one_op_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> $countones({fill_i, nib_we_i, inv_i}) <= 1);
endmodule

// File: rtl/cdram_timer.sv
module cdram_timer #(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned BUSY_MAX = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lat_ld_i,
  input  logic [CNT_W-1:0] busy_ld_i,
  output logic             lat_zero_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] lat_q, busy_q;

  assign lat_zero_o = (lat_q == '0);
  assign busy_o     = (busy_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      busy_q <= '0;
    end else if (en_i) begin
      if (start_i) begin
        lat_q  <= lat_ld_i;
        busy_q <= busy_ld_i;
      end else begin
        if (lat_q != '0)  lat_q  <= lat_q - CNT_W'(1);
        if (busy_q != '0) busy_q <= busy_q - CNT_W'(1);
      end
    end
  end

  p_array_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && start_i |-> !busy_o);
  p_busy_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q <= CNT_W'(BUSY_MAX));
  p_pd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(busy_q) && $stable(lat_q));
endmodule

// File: rtl/cdram_seq.sv
module cdram_seq
  import cdram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned OFS_W     = 4,
  parameter int unsigned SET_W     = 8,
  parameter int unsigned MISS_LAT  = 7,
  parameter int unsigned MISS_BUSY = 28,
  parameter int unsigned DIR_LAT   = 7,
  parameter int unsigned DIR_BUSY  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic              req_direct_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_wdata_i,
  output logic              rsp_valid_o,
  output logic [3:0]        rsp_rdata_o
);
  localparam int unsigned TAG_W    = ADDR_W - SET_W - OFS_W;
  localparam int unsigned IDX_W    = ADDR_W - OFS_W;
  localparam int unsigned LINE_W   = NIB_W << OFS_W;
  localparam int unsigned BUSY_MAX = (MISS_BUSY > DIR_BUSY) ? MISS_BUSY - 1 : DIR_BUSY - 1;
  localparam int unsigned CNT_W    = $clog2(BUSY_MAX + 1);

  logic [OFS_W-1:0]  ofs;
  logic [SET_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  logic [IDX_W-1:0]  line_idx;
  logic [OFS_W+1:0]  bpos;
  logic              en, hit, vic_dirty, busy, lat_zero;
  logic [TAG_W-1:0]  vic_tag;
  logic [LINE_W-1:0] c_line, a_line, fill_line, dw_line, a_wr_line;
  logic [IDX_W-1:0]  a_wr_idx;
  logic              fire, hit_acc, arr_acc, a_line_we, a_nib_we;
  logic              c_fill, c_nib_we, c_inv;
  logic [3:0]        rdata_n, rdata_q;
  logic              rsp_q;
  seq_state_e        state_q;

  assign ofs      = req_addr_i[OFS_W-1:0];
  assign set      = req_addr_i[OFS_W +: SET_W];
  assign tag      = req_addr_i[ADDR_W-1 -: TAG_W];
  assign line_idx = req_addr_i[ADDR_W-1:OFS_W];
  assign bpos     = {ofs, 2'b00};
  assign en       = !pd_i;

  // hits never wait for the array; misses and bypass accesses do
  assign req_ready_o = en && (state_q == ST_IDLE) && (!busy || (!req_direct_i && hit));
  assign fire        = req_valid_i && req_ready_o;
  assign hit_acc     = fire && !req_direct_i && hit;
  assign arr_acc     = fire && (req_direct_i || !hit);

  always_comb begin
    fill_line = a_line;
    dw_line   = c_line;
    if (req_we_i) begin
      fill_line[bpos +: 4] = req_wdata_i;
      dw_line[bpos +: 4]   = req_wdata_i;
    end
  end

  // line copy-back: dirty victim on a miss, or dirty hit line on a bypass write
  always_comb begin
    a_line_we = 1'b0;
    a_wr_idx  = {vic_tag, set};
    a_wr_line = c_line;
    if (fire && !req_direct_i && !hit && vic_dirty) begin
      a_line_we = 1'b1;
    end else if (fire && req_direct_i && req_we_i && hit && vic_dirty) begin
      a_line_we = 1'b1;
      a_wr_idx  = line_idx;
      a_wr_line = dw_line;
    end
  end

  assign a_nib_we = fire && req_direct_i && req_we_i && !a_line_we;
  assign c_fill   = fire && !req_direct_i && !hit;
  assign c_nib_we = hit_acc && req_we_i;
  assign c_inv    = fire && req_direct_i && req_we_i && hit;

  assign rdata_n = req_we_i ? req_wdata_i
                 : (hit ? c_line[bpos +: 4] : a_line[bpos +: 4]);

  cdram_array #(.IDX_W(IDX_W), .OFS_W(OFS_W)) i_array (
    .clk_i          (clk_i),
    .en_i           (en),
    .line_we_i      (a_line_we),
    .line_wr_idx_i  (a_wr_idx),
    .line_wr_data_i (a_wr_line),
    .nib_we_i       (a_nib_we),
    .nib_addr_i     (req_addr_i),
    .nib_data_i     (req_wdata_i),
    .line_rd_idx_i  (line_idx),
    .line_rd_o      (a_line)
  );

  cdram_cache #(.SET_W(SET_W), .TAG_W(TAG_W), .OFS_W(OFS_W)) i_cache (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .set_i        (set),
    .tag_i        (tag),
    .hit_o        (hit),
    .vic_dirty_o  (vic_dirty),
    .vic_tag_o    (vic_tag),
    .line_o       (c_line),
    .fill_i       (c_fill),
    .fill_line_i  (fill_line),
    .fill_dirty_i (req_we_i),
    .nib_we_i     (c_nib_we),
    .nib_ofs_i    (ofs),
    .nib_data_i   (req_wdata_i),
    .inv_i        (c_inv)
  );

  cdram_timer #(.CNT_W(CNT_W), .BUSY_MAX(BUSY_MAX)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .start_i    (arr_acc),
    .lat_ld_i   (req_direct_i ? CNT_W'(DIR_LAT - 2) : CNT_W'(MISS_LAT - 2)),
    .busy_ld_i  (req_direct_i ? CNT_W'(DIR_BUSY - 1) : CNT_W'(MISS_BUSY - 1)),
    .lat_zero_o (lat_zero),
    .busy_o     (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else if (en) begin
      rsp_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (fire) begin
          rdata_q <= rdata_n;
          if (hit_acc) rsp_q <= 1'b1;
          else         state_q <= ST_WAIT;
        end
        ST_WAIT: if (lat_zero) begin
          rsp_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_q && en;
  assign rsp_rdata_o = rdata_q;

  p_wait_no_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !req_ready_o);
  p_miss_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_acc |=> !rsp_q);
  p_hit_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_acc |=> rsp_q);
  p_pd_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> $stable(state_q) && $stable(rdata_q) && $stable(rsp_q));
endmodule

// File: tb/test_cdram_seq.sv
module test_cdram_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic        we = 1'b0;
  logic        dir = 1'b0;
  logic [13:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int last_acc = 0;
  int m0, h0, a0;
  bit done = 1'b0;

  logic [3:0] qd[$];
  int         ql[$];
  int         qa[$];
  string      qs[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdram_seq i_cdram_seq (
    .clk_i (clk), .rst_ni (rst_n), .pd_i (pd),
    .req_valid_i (valid), .req_ready_o (ready), .req_we_i (we),
    .req_direct_i (dir), .req_addr_i (addr), .req_wdata_i (wdata),
    .rsp_valid_o (rsp_valid), .rsp_rdata_o (rsp_rdata)
  );

  function automatic logic [13:0] mk(input logic [1:0] t, input logic [7:0] s, input logic [3:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input string r, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // call and return just after a falling edge
  task automatic do_req(input logic w, input logic d, input logic [13:0] a,
                        input logic [3:0] wd, input logic [3:0] ed, input int lat, input string r);
    valid = 1'b1; we = w; dir = d; addr = a; wdata = wd;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    last_acc = cyc;
    qd.push_back(ed); ql.push_back(lat); qa.push_back(cyc); qs.push_back(r);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic drain();
    while (qd.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #5;
    if (rst_n && rsp_valid) begin
      if (qd.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R9 unexpected response: actual data %0d expected none", rsp_rdata);
      end else begin
        logic [3:0] ed;
        int el, ea;
        string r;
        ed = qd.pop_front(); el = ql.pop_front(); ea = qa.pop_front(); r = qs.pop_front();
        chk(r, int'(rsp_rdata), int'(ed), "response data");
        chk(r, cyc - ea, el, "response latency");
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", int'(ready), 1, "ready after reset");
    chk("R1", int'(rsp_valid), 0, "no response after reset");
    @(negedge clk);

    // R5: bypass writes, spaced by array occupancy
    do_req(1, 1, mk(0, 1, 0), 4'h5, 4'h5, 7, "R5");
    a0 = last_acc;
    do_req(1, 1, mk(0, 1, 3), 4'h9, 4'h9, 7, "R5");
    chk("R5", last_acc - a0, 14, "bypass start spacing");
    do_req(1, 1, mk(1, 1, 0), 4'hC, 4'hC, 7, "R5");
    do_req(1, 1, mk(0, 2, 5), 4'h7, 4'h7, 7, "R5");

    // R1/R3: first cached read misses
    do_req(0, 0, mk(0, 1, 0), 4'h0, 4'h5, 7, "R3");
    m0 = last_acc;
    #1 chk("R3", int'(ready), 0, "ready low during miss wait");
    // R4: hit released after miss access time
    do_req(0, 0, mk(0, 1, 3), 4'h0, 4'h9, 1, "R4");
    chk("R4", last_acc - m0, 7, "hit accepted after miss");
    do_req(0, 0, mk(0, 1, 0), 4'h0, 4'h5, 1, "R2");
    h0 = last_acc;
    do_req(0, 0, mk(0, 1, 3), 4'h0, 4'h9, 1, "R2");
    chk("R2", last_acc - h0, 1, "back-to-back hits");
    // R4: array held by background copy-back
    do_req(0, 1, mk(0, 2, 5), 4'h0, 4'h7, 7, "R5");
    chk("R4", last_acc - m0, 28, "array request waits for copy-back");

    // R6: write hit
    do_req(1, 0, mk(0, 1, 3), 4'hA, 4'hA, 1, "R6");
    do_req(0, 0, mk(0, 1, 3), 4'h0, 4'hA, 1, "R6");

    // R7: dirty eviction
    do_req(0, 0, mk(1, 1, 0), 4'h0, 4'hC, 7, "R7");
    do_req(0, 0, mk(0, 1, 3), 4'h0, 4'hA, 7, "R7");
    do_req(0, 0, mk(0, 1, 0), 4'h0, 4'h5, 1, "R7");

    // R8: bypass write invalidates clean line
    do_req(1, 1, mk(0, 1, 0), 4'h3, 4'h3, 7, "R8");
    do_req(0, 0, mk(0, 1, 0), 4'h0, 4'h3, 7, "R8");
    // R8: bypass write on dirty line keeps other nibbles
    do_req(1, 0, mk(0, 1, 3), 4'h6, 4'h6, 1, "R8");
    do_req(1, 1, mk(0, 1, 0), 4'h2, 4'h2, 7, "R8");
    do_req(0, 0, mk(0, 1, 3), 4'h0, 4'h6, 7, "R8");
    do_req(0, 0, mk(0, 1, 0), 4'h0, 4'h2, 1, "R8");

    // R5: bypass read did not allocate set 2
    do_req(0, 0, mk(0, 2, 5), 4'h0, 4'h7, 7, "R5");
    drain();

    // R9: power-down
    pd = 1'b1;
    #1 chk("R9", int'(ready), 0, "ready low in power-down");
    @(negedge clk);
    pd = 1'b0;
    do_req(0, 0, mk(1, 1, 0), 4'h0, 4'hC, 17, "R9");
    pd = 1'b1;
    repeat (10) @(negedge clk);
    pd = 1'b0;
    drain();
    do_req(0, 0, mk(1, 1, 0), 4'h0, 4'hC, 1, "R9");
    drain();
    repeat (5) @(negedge clk);
    chk("R9", qd.size(), 0, "no pending responses");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule